// File: doc/BRIEF.md
# Output Code Slew Rate Controller

This block sits between the committed converter code and the converter core. With ramping switched off, a newly committed code goes to the core at the next clock edge. With ramping switched on, the driven code moves toward its destination in steps: one step of a selectable size on each tick of a selectable prescaler. The final step is clamped so that the code lands exactly on the destination. A busy flag reports that a ramp is still in progress, so a host can poll it before it writes again.

The same ramp engine handles the clear request. Clear sends the destination to code zero and records the destination that was in force before the clear. While clear is high, new codes are refused. After clear falls, the output stays at zero until a restore strobe sends it back to the recorded value. A control-register write freezes a ramp in progress at its present code.

Top module: `slew_ramp_ctrl`

## Requirements
- R1: With `ramp_en` low, a `tgt_load` pulse makes `out_code` equal `tgt_code` after the next rising clock edge.
- R2: With `ramp_en` high, `out_code` moves by 2^`step_sel` codes per step. Steps come every 2^`rate_sel` clock cycles, and the first step lands 2^`rate_sel` edges after the edge that took the new destination.
- R3: The last step of a ramp is clamped to the destination, so there is no overshoot. This holds for rising and falling ramps and over the whole code range 0x0000 to 0xFFFF.
- R4: `ramp_busy` is high exactly when `ramp_en` is high and `out_code` differs from the destination. It falls on the same edge as the final step.
- R5: While `clr_req` is high, the destination is code 0 and the output ramps there at the programmed rate; `tgt_load` is ignored. With `ramp_en` low, the output goes to 0 at the next edge.
- R6: After `clr_req` falls, the output stays at 0 until a `restore_pulse`. The pulse sends the output back, at the programmed rate, to the destination that held when the clear began.
- R7: A `restore_pulse` given when no clear has happened since the last `tgt_load` or restore has no effect.
- R8: A `ctl_write` pulse during a ramp freezes `out_code` at its present value and drops `ramp_busy`. If a step tick falls in the same cycle, the step is suppressed.
- R9: When several requests occur in one cycle, `clr_req` wins over `ctl_write`, `ctl_write` over `restore_pulse`, and `restore_pulse` over `tgt_load`.
- R10: After reset, `out_code` is 0 and `ramp_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tgt_code | input | 16 | Newly committed code |
| tgt_load | input | 1 | One-cycle strobe that commits `tgt_code` |
| ramp_en | input | 1 | Enables stepped ramping |
| rate_sel | input | 4 | Prescaler select, one step every 2^n cycles |
| step_sel | input | 3 | Step size select, 2^n codes |
| ctl_write | input | 1 | Control-register write strobe, freezes a ramp |
| clr_req | input | 1 | Clear request, level |
| restore_pulse | input | 1 | Strobe that returns the output to its pre-clear value |
| out_code | output | 16 | Code driven to the converter core |
| ramp_busy | output | 1 | High while a ramp is in progress |

## Verification
Two same-cycle collisions are tested. In the first, a control-register write is timed to arrive on the exact cycle in which a prescaler tick would apply a step. The output must keep the value from the previous step and must not move afterwards. In the second, a clear and a new code are presented together; the output must ramp toward zero and ignore the code. The ramp sweep covers every step size with several prescaler rates in both directions. The bench predicts each cycle's code from the elapsed edge count, so an early step, a late step or an overshot step is reported.

// File: rtl/slew_pkg.sv
// Shared sizing for the slew rate controller.
// Assumes the largest step (2^(2^STEP_SEL_W - 1)) fits in the code width.
package slew_pkg;
    localparam int CODE_W     = 16;
    localparam int STEP_SEL_W = 3;
    localparam int RATE_SEL_W = 4;
endpackage

// File: rtl/slew_tick_gen.sv
// Prescaler that produces step ticks while a ramp is active.
// Assumes: the counter restarts whenever no ramp is active, so the first
// tick of a ramp comes 2^rate_sel cycles after it starts.
module slew_tick_gen #(
    parameter int RATE_SEL_W = slew_pkg::RATE_SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  busy,
    input  logic [RATE_SEL_W-1:0] rate_sel,
    output logic                  tick
);
    localparam int CNT_W = 1 << RATE_SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected divide ratio.
    always_comb limit = (CNT_W'(1) << rate_sel) - CNT_W'(1);

    assign tick = busy && (cnt_q >= limit);

    // Count cycles between ticks; hold at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!busy || tick) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/slew_step_unit.sv
// Combinational step calculator: moves the current code one step toward
// the destination and clamps at the destination.
// Assumes: the step select is small enough that the step fits CODE_W bits.
module slew_step_unit #(
    parameter int CODE_W     = slew_pkg::CODE_W,
    parameter int STEP_SEL_W = slew_pkg::STEP_SEL_W
) (
    input  logic [CODE_W-1:0]     cur,
    input  logic [CODE_W-1:0]     goal,
    input  logic [STEP_SEL_W-1:0] step_sel,
    output logic [CODE_W-1:0]     nxt
);
    logic              rising;
    logic [CODE_W-1:0] gap;
    logic [CODE_W-1:0] step_w;

    // Choose the direction, measure the gap and clamp the last step.
    always_comb begin
        rising = goal > cur;
        gap    = rising ? (goal - cur) : (cur - goal);
        step_w = CODE_W'(1) << step_sel;
        if (gap <= step_w) nxt = goal;
        else if (rising)   nxt = cur + step_w;
        else               nxt = cur - step_w;
    end
endmodule

// File: rtl/slew_target_ctl.sv
// Destination register with clear, restore, freeze and load handling.
// Priority: clear > control write (freeze) > restore > load.
// Assumes: strobes are one cycle wide; clr_req is a level.
module slew_target_ctl #(
    parameter int CODE_W = slew_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              tgt_load,
    input  logic              ctl_write,
    input  logic              clr_req,
    input  logic              restore_pulse,
    input  logic [CODE_W-1:0] out_code,
    output logic [CODE_W-1:0] goal_q,
    output logic [CODE_W-1:0] goal_nxt
);
    logic [CODE_W-1:0] saved_q;
    logic              armed_q;

    // Next destination under the request priority.
    always_comb begin
        if (clr_req)                         goal_nxt = '0;
        else if (ctl_write)                  goal_nxt = out_code;
        else if (restore_pulse && armed_q)   goal_nxt = saved_q;
        else if (tgt_load)                   goal_nxt = tgt_code;
        else                                 goal_nxt = goal_q;
    end

    // Register the destination.
    always_ff @(posedge clk) begin
        if (!rst_n) goal_q <= '0;
        else        goal_q <= goal_nxt;
    end

    // Record the pre-clear destination on the first clear cycle and track restore eligibility.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_q <= '0;
            armed_q <= 1'b0;
        end else if (clr_req) begin
            if (!armed_q) saved_q <= goal_q;
            armed_q <= 1'b1;
        end else if (!ctl_write && (restore_pulse || tgt_load)) begin
            armed_q <= 1'b0;
        end
    end

    // R5: a clear forces the destination to zero.
    a_r5_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> goal_q == '0);

    // R6: after a clear, the destination holds until something changes it.
    a_r6_hold_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !clr_req && !tgt_load && !restore_pulse && !ctl_write)
        |=> goal_q == $past(goal_q));

    // R7: a restore without a preceding clear leaves the destination alone.
    a_r7_restore_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_pulse && !armed_q && !clr_req && !ctl_write && !tgt_load)
        |=> $stable(goal_q));
endmodule

// File: rtl/slew_ramp_ctrl.sv
// Top of the slew rate controller. Drives the converter code either
// straight from the destination or in clamped steps paced by the prescaler.
// Assumes: synchronous active-low reset; strobes last one cycle.
module slew_ramp_ctrl #(
    parameter int CODE_W     = slew_pkg::CODE_W,
    parameter int STEP_SEL_W = slew_pkg::STEP_SEL_W,
    parameter int RATE_SEL_W = slew_pkg::RATE_SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CODE_W-1:0]     tgt_code,
    input  logic                  tgt_load,
    input  logic                  ramp_en,
    input  logic [RATE_SEL_W-1:0] rate_sel,
    input  logic [STEP_SEL_W-1:0] step_sel,
    input  logic                  ctl_write,
    input  logic                  clr_req,
    input  logic                  restore_pulse,
    output logic [CODE_W-1:0]     out_code,
    output logic                  ramp_busy
);
    logic [CODE_W-1:0] goal_q;
    logic [CODE_W-1:0] goal_nxt;
    logic [CODE_W-1:0] step_nxt;
    logic              tick;

    slew_target_ctl #(.CODE_W(CODE_W)) u_target (
        .clk(clk), .rst_n(rst_n), .tgt_code(tgt_code), .tgt_load(tgt_load),
        .ctl_write(ctl_write), .clr_req(clr_req), .restore_pulse(restore_pulse),
        .out_code(out_code), .goal_q(goal_q), .goal_nxt(goal_nxt)
    );

    slew_tick_gen #(.RATE_SEL_W(RATE_SEL_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .busy(ramp_busy), .rate_sel(rate_sel), .tick(tick)
    );

    slew_step_unit #(.CODE_W(CODE_W), .STEP_SEL_W(STEP_SEL_W)) u_step (
        .cur(out_code), .goal(goal_q), .step_sel(step_sel), .nxt(step_nxt)
    );

    assign ramp_busy = ramp_en && (out_code != goal_q);

    // Update the driven code: direct, frozen, or one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_code <= '0;
        else if (!ramp_en)  out_code <= goal_nxt;
        else if (ctl_write) out_code <= out_code;
        else if (tick)      out_code <= step_nxt;
    end

    // R1: with ramping off, a load appears at the next edge.
    a_r1_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!ramp_en && tgt_load && !clr_req && !ctl_write && !restore_pulse)
        |=> out_code == $past(tgt_code));

    // R2: a step moves by exactly the selected size unless it lands on the destination.
    a_r2_step_size: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en && tick && !ctl_write)
        |=> (out_code == $past(goal_q)) ||
            ((out_code > $past(out_code) ? out_code - $past(out_code)
                                         : $past(out_code) - out_code)
             == (CODE_W'(1) << $past(step_sel))));

    // R3: a step never passes the destination.
    a_r3_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en && tick && !ctl_write)
        |=> (out_code >= $past(out_code) && out_code <= $past(goal_q)) ||
            (out_code <= $past(out_code) && out_code >= $past(goal_q)));

    // R8: a control write freezes the code and ends the ramp.
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en && ctl_write && !clr_req)
        |=> (out_code == $past(out_code)) && !ramp_busy);

    // R4: an idle, enabled ramp with no requests keeps the code still.
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en && !ramp_busy && !tgt_load && !clr_req && !restore_pulse && !ctl_write)
        |=> $stable(out_code));
endmodule

// File: tb/slew_ramp_ctrl_test.sv
module slew_ramp_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tgt_code = '0;
    logic        tgt_load = 1'b0;
    logic        ramp_en = 1'b0;
    logic [3:0]  rate_sel = '0;
    logic [2:0]  step_sel = '0;
    logic        ctl_write = 1'b0;
    logic        clr_req = 1'b0;
    logic        restore_pulse = 1'b0;
    logic [15:0] out_code;
    logic        ramp_busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    slew_ramp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tgt_code(tgt_code), .tgt_load(tgt_load),
        .ramp_en(ramp_en), .rate_sel(rate_sel), .step_sel(step_sel),
        .ctl_write(ctl_write), .clr_req(clr_req), .restore_pulse(restore_pulse),
        .out_code(out_code), .ramp_busy(ramp_busy)
    );

    task automatic chk16(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s out_code actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s ramp_busy actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Strobe a new code; returns at the negedge right after the taking edge.
    task automatic load(logic [15:0] v);
        tgt_code = v;
        tgt_load = 1'b1;
        @(negedge clk);
        tgt_load = 1'b0;
    endtask

    // Check every cycle of a ramp from start to target (R2, R3, R4).
    task automatic run_ramp(string req, int start, int target, int div, int step);
        int diff = (target > start) ? target - start : start - target;
        int nsteps = (diff + step - 1) / step;
        for (int k = 1; k <= nsteps * div + 2; k++) begin
            int mv = (k / div) * step;
            int ex;
            @(negedge clk);
            if (mv >= diff) ex = target;
            else ex = (target > start) ? start + mv : start - mv;
            chk16(req, out_code, 16'(ex));
            chk1("R4", ramp_busy, 1'(ex != target));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk16("R10", out_code, 16'h0000);
        chk1("R10", ramp_busy, 1'b0);

        // R1: direct path with ramping off
        load(16'h1234);
        chk16("R1", out_code, 16'h1234);
        chk1("R1", ramp_busy, 1'b0);
        // R5: clear with ramping off goes to zero at the next edge
        clr_req = 1'b1;
        @(negedge clk);
        chk16("R5", out_code, 16'h0000);
        clr_req = 1'b0;
        load(16'h0000);

        // R2/R3 sweep: every step size, four rates, up then down
        ramp_en = 1'b1;
        for (int s = 0; s < 8; s++) begin
            for (int r = 0; r < 4; r++) begin
                int tgt = 37 * (1 << s) + 3;
                step_sel = 3'(s);
                rate_sel = 4'(r);
                load(16'(tgt));
                chk16("R2", out_code, 16'h0000);
                run_ramp("R2", 0, tgt, 1 << r, 1 << s);
                load(16'h0000);
                run_ramp("R3", tgt, 0, 1 << r, 1 << s);
            end
        end

        // R3: full range, clamp at the top and a long fall to a near-zero code
        ramp_en = 1'b0;
        load(16'hFFF0);
        ramp_en = 1'b1;
        step_sel = 3'd7;
        rate_sel = 4'd0;
        load(16'hFFFF);
        run_ramp("R3", 16'hFFF0, 16'hFFFF, 1, 128);
        load(16'h0005);
        run_ramp("R3", 16'hFFFF, 16'h0005, 1, 128);

        // R5/R9: clear and load in the same cycle; clear wins and ramps down
        step_sel = 3'd2;
        rate_sel = 4'd1;
        load(16'd100);
        run_ramp("R2", 5, 100, 2, 4);
        clr_req = 1'b1;
        load(16'd500);
        chk16("R9", out_code, 16'd100);
        run_ramp("R5", 100, 0, 2, 4);
        load(16'd700);
        chk16("R5", out_code, 16'd0);
        chk1("R5", ramp_busy, 1'b0);
        // R6: after release the output stays at zero, then a restore returns it
        clr_req = 1'b0;
        repeat (6) @(negedge clk);
        chk16("R6", out_code, 16'd0);
        chk1("R6", ramp_busy, 1'b0);
        restore_pulse = 1'b1;
        @(negedge clk);
        restore_pulse = 1'b0;
        run_ramp("R6", 0, 100, 2, 4);

        // R7: restore with no clear since the last load has no effect
        load(16'd40);
        run_ramp("R2", 100, 40, 2, 4);
        restore_pulse = 1'b1;
        @(negedge clk);
        restore_pulse = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk16("R7", out_code, 16'd40);
            chk1("R7", ramp_busy, 1'b0);
        end

        // R8: control write on the same edge as the third step
        step_sel = 3'd0;
        rate_sel = 4'd2;
        load(16'd1000);
        repeat (11) @(negedge clk);
        chk16("R8", out_code, 16'd42);
        ctl_write = 1'b1;
        @(negedge clk);
        ctl_write = 1'b0;
        chk16("R8", out_code, 16'd42);
        chk1("R8", ramp_busy, 1'b0);
        repeat (10) @(negedge clk);
        chk16("R8", out_code, 16'd42);
        chk1("R8", ramp_busy, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule